// File: doc/BRIEF.md
# Scratchpad Address Generator for a Tiled Convolution Dataflow

This block sits inside one processing element of a convolution accelerator. It walks the innermost tile loops of the local computation: output channel, input channel, filter row, output row, batch and output column. For every step of that walk it produces three local scratchpad addresses: one for the partial sum, one for the weight and one for the input activation. A valid strobe and a last-step flag accompany each address triple.

Each address uses its own linear layout. Output channel varies fastest in the partial-sum and weight layouts, and input channel varies fastest in the input layout. The weight address does not depend on the output row, batch or output column counters, so a weight word is fetched again while those counters move. A `start_i` pulse latches the six tile sizes and begins the walk. When the final step has been issued, `done_o` pulses for one cycle.

Top module: `spad_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `valid_o`, `last_o` and `done_o` are low.
- R2: When `start_i` is high while `valid_o` is low, the six size fields are captured, and `valid_o` rises on the next cycle with all three addresses equal to 0. Each size field holds the tile count minus one, so counts range from 1 to 16. After capture, changes on the size inputs have no effect on the walk.
- R3: After start, exactly one step is issued per cycle with no gap, for M·C·R·E·N·F steps in total. The loop order from outermost to innermost is output column (f), batch (n), output row (e), filter row (r), input channel (c), output channel (m).
- R4: The partial-sum address equals m + e·M + n·E·M + f·N·E·M.
- R5: The weight address equals m + c·M + r·C·M, and is independent of e, n and f.
- R6: The input address equals c + r·C + e·R·C + n·E·R·C + f·N·E·R·C.
- R7: `last_o` is high on the final step of a walk and low on every other cycle.
- R8: In the cycle after the final step, `done_o` is high for exactly one cycle and `valid_o` is low.
- R9: `start_i` is ignored while a walk is in progress. Neither the sequence nor the sizes change.
- R10: Each address is reduced modulo 2^ADDR_W.
- R11: When all size fields are 0, the walk is a single step on which `valid_o` and `last_o` are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a walk when idle |
| m_size_i | input | SZ_W | Output-channel tile count minus one |
| c_size_i | input | SZ_W | Input-channel tile count minus one |
| r_size_i | input | SZ_W | Filter-row tile count minus one |
| e_size_i | input | SZ_W | Output-row tile count minus one |
| n_size_i | input | SZ_W | Batch tile count minus one |
| f_size_i | input | SZ_W | Output-column tile count minus one |
| psum_addr_o | output | ADDR_W | Partial-sum scratchpad address |
| wgt_addr_o | output | ADDR_W | Weight scratchpad address |
| ifm_addr_o | output | ADDR_W | Input-activation scratchpad address |
| valid_o | output | 1 | Address triple is valid this cycle |
| last_o | output | 1 | Final step of the walk |
| done_o | output | 1 | One-cycle pulse after the final step |

## Verification
Every step's address triple is compared against the closed-form layouts, so a wrong loop counter or a stale stride term shows at the ports in the very cycle it is used. A carry that reaches the wrong level shows at the next wrap of the inner loop. A bad end-of-walk count appears as an early or missing `last_o`, or as a `done_o` in the wrong cycle. A start that is not properly gated, or sizes that are not properly latched, causes a divergence on the first step after the disturbance.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int SZ_W   = 4;
  localparam int ADDR_W = 10;
  localparam int NLVL   = 6;
  // loop levels, innermost first
  localparam int LV_M = 0;
  localparam int LV_C = 1;
  localparam int LV_R = 2;
  localparam int LV_E = 3;
  localparam int LV_N = 4;
  localparam int LV_F = 5;
endpackage

// File: rtl/sag_stride.sv
module sag_stride
  import sag_pkg::*;
#(
  parameter int SZ_W   = sag_pkg::SZ_W,
  parameter int ADDR_W = sag_pkg::ADDR_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [NLVL-1:0][SZ_W-1:0]        size_i,
  output logic [NLVL-1:0][SZ_W-1:0]        max_o,
  output logic [NLVL-1:0][ADDR_W-1:0]      psum_stride_o,
  output logic [NLVL-1:0][ADDR_W-1:0]      wgt_stride_o,
  output logic [NLVL-1:0][ADDR_W-1:0]      ifm_stride_o
);
  logic [NLVL-1:0][ADDR_W-1:0] cnt;
  logic [NLVL-1:0][ADDR_W-1:0] ps_d, ws_d, is_d;
  logic [ADDR_W-1:0] em, nem, cm, rc, erc, nerc;

  always_comb begin
    for (int k = 0; k < NLVL; k++) cnt[k] = ADDR_W'(size_i[k]) + ADDR_W'(1);
    em   = cnt[LV_E] * cnt[LV_M];
    nem  = cnt[LV_N] * em;
    cm   = cnt[LV_C] * cnt[LV_M];
    rc   = cnt[LV_R] * cnt[LV_C];
    erc  = cnt[LV_E] * rc;
    nerc = cnt[LV_N] * erc;
    ps_d = '0;
    ws_d = '0;
    is_d = '0;
    ps_d[LV_M] = ADDR_W'(1);
    ps_d[LV_E] = cnt[LV_M];
    ps_d[LV_N] = em;
    ps_d[LV_F] = nem;
    ws_d[LV_M] = ADDR_W'(1);
    ws_d[LV_C] = cnt[LV_M];
    ws_d[LV_R] = cm;
    is_d[LV_C] = ADDR_W'(1);
    is_d[LV_R] = cnt[LV_C];
    is_d[LV_E] = rc;
    is_d[LV_N] = erc;
    is_d[LV_F] = nerc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_o         <= '0;
      psum_stride_o <= '0;
      wgt_stride_o  <= '0;
      ifm_stride_o  <= '0;
    end else if (load_i) begin
      max_o         <= size_i;
      psum_stride_o <= ps_d;
      wgt_stride_o  <= ws_d;
      ifm_stride_o  <= is_d;
    end
  end
endmodule

// File: rtl/sag_loop_nest.sv
module sag_loop_nest
  import sag_pkg::*;
#(
  parameter int SZ_W = sag_pkg::SZ_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      step_i,
  input  logic [NLVL-1:0][SZ_W-1:0] max_i,
  output logic [NLVL-1:0]           inc_o,
  output logic [NLVL-1:0]           wrap_o,
  output logic                      last_o
);
  logic [NLVL-1:0][SZ_W-1:0] idx_q;

  always_comb begin
    for (int k = 0; k < NLVL; k++) wrap_o[k] = (idx_q[k] == max_i[k]);
    inc_o[0] = step_i;
    for (int k = 1; k < NLVL; k++) inc_o[k] = inc_o[k-1] & wrap_o[k-1];
  end

  assign last_o = &wrap_o;

  for (genvar k = 0; k < NLVL; k++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        idx_q[k] <= '0;
      else if (clear_i)   idx_q[k] <= '0;
      else if (inc_o[k])  idx_q[k] <= wrap_o[k] ? '0 : idx_q[k] + SZ_W'(1);
    end
  end
endmodule

// File: rtl/sag_addr_acc.sv
module sag_addr_acc
  import sag_pkg::*;
#(
  parameter int ADDR_W = sag_pkg::ADDR_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic [NLVL-1:0]             inc_i,
  input  logic [NLVL-1:0]             wrap_i,
  input  logic [NLVL-1:0][ADDR_W-1:0] stride_i,
  output logic [ADDR_W-1:0]           addr_o
);
  // term k holds idx_k * stride_k, kept by addition only
  logic [NLVL-1:0][ADDR_W-1:0] term_q;

  for (genvar k = 0; k < NLVL; k++) begin : g_term
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       term_q[k] <= '0;
      else if (clear_i)  term_q[k] <= '0;
      else if (inc_i[k]) term_q[k] <= wrap_i[k] ? '0 : term_q[k] + stride_i[k];
    end
  end

  always_comb begin
    addr_o = '0;
    for (int k = 0; k < NLVL; k++) addr_o = addr_o + term_q[k];
  end
endmodule

// File: rtl/spad_addr_gen.sv
module spad_addr_gen
  import sag_pkg::*;
#(
  parameter int SZ_W   = sag_pkg::SZ_W,
  parameter int ADDR_W = sag_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SZ_W-1:0]   m_size_i,
  input  logic [SZ_W-1:0]   c_size_i,
  input  logic [SZ_W-1:0]   r_size_i,
  input  logic [SZ_W-1:0]   e_size_i,
  input  logic [SZ_W-1:0]   n_size_i,
  input  logic [SZ_W-1:0]   f_size_i,
  output logic [ADDR_W-1:0] psum_addr_o,
  output logic [ADDR_W-1:0] wgt_addr_o,
  output logic [ADDR_W-1:0] ifm_addr_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              done_o
);
  logic                        run_q, done_q, accept, nest_last;
  logic [NLVL-1:0][SZ_W-1:0]   size_vec, max_q;
  logic [NLVL-1:0]             inc, wrap;
  logic [NLVL-1:0][ADDR_W-1:0] ps_stride, ws_stride, is_stride;

  assign size_vec = {f_size_i, n_size_i, e_size_i, r_size_i, c_size_i, m_size_i};
  assign accept   = start_i & ~run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= run_q & nest_last;
      if (accept)                 run_q <= 1'b1;
      else if (run_q & nest_last) run_q <= 1'b0;
    end
  end

  sag_stride #(.SZ_W(SZ_W), .ADDR_W(ADDR_W)) u_stride (
    .clk_i, .rst_ni, .load_i(accept), .size_i(size_vec), .max_o(max_q),
    .psum_stride_o(ps_stride), .wgt_stride_o(ws_stride), .ifm_stride_o(is_stride)
  );

  sag_loop_nest #(.SZ_W(SZ_W)) u_nest (
    .clk_i, .rst_ni, .clear_i(accept), .step_i(run_q), .max_i(max_q),
    .inc_o(inc), .wrap_o(wrap), .last_o(nest_last)
  );

  sag_addr_acc #(.ADDR_W(ADDR_W)) u_psum (
    .clk_i, .rst_ni, .clear_i(accept), .inc_i(inc), .wrap_i(wrap),
    .stride_i(ps_stride), .addr_o(psum_addr_o)
  );

  sag_addr_acc #(.ADDR_W(ADDR_W)) u_wgt (
    .clk_i, .rst_ni, .clear_i(accept), .inc_i(inc), .wrap_i(wrap),
    .stride_i(ws_stride), .addr_o(wgt_addr_o)
  );

  sag_addr_acc #(.ADDR_W(ADDR_W)) u_ifm (
    .clk_i, .rst_ni, .clear_i(accept), .inc_i(inc), .wrap_i(wrap),
    .stride_i(is_stride), .addr_o(ifm_addr_o)
  );

  assign valid_o = run_q;
  assign last_o  = run_q & nest_last;
  assign done_o  = done_q;
endmodule

// File: rtl/sag_chk.sv
module sag_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] psum_addr_o,
  input logic [ADDR_W-1:0] wgt_addr_o,
  input logic [ADDR_W-1:0] ifm_addr_o,
  input logic              valid_o,
  input logic              last_o,
  input logic              done_o
);
  // R7
  last_in_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  // R8
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && last_o) |=> (done_o && !valid_o));
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3
  no_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> valid_o);
  // R2
  idle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_o) |=> valid_o);
  // R2
  first_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (psum_addr_o == '0 && wgt_addr_o == '0 && ifm_addr_o == '0));
endmodule

bind spad_addr_gen sag_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_spad_addr_gen.sv
module tb_spad_addr_gen;
  localparam int SZ_W   = 4;
  localparam int ADDR_W = 10;
  localparam int AMASK  = (1 << ADDR_W) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [SZ_W-1:0] m_size_i = '0, c_size_i = '0, r_size_i = '0;
  logic [SZ_W-1:0] e_size_i = '0, n_size_i = '0, f_size_i = '0;
  logic [ADDR_W-1:0] psum_addr_o, wgt_addr_o, ifm_addr_o;
  logic valid_o, last_o, done_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;

  spad_addr_gen #(.SZ_W(SZ_W), .ADDR_W(ADDR_W)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic set_sizes(input int fm, fc, fr, fe, fn, ff);
    m_size_i = SZ_W'(fm); c_size_i = SZ_W'(fc); r_size_i = SZ_W'(fr);
    e_size_i = SZ_W'(fe); n_size_i = SZ_W'(fn); f_size_i = SZ_W'(ff);
  endtask

  // walks one full nest; poke >= 0 raises start_i (with other sizes) at that step
  task automatic run_case(input int fm, fc, fr, fe, fn, ff, input int poke, input string tag);
    int mm = fm + 1, cc = fc + 1, rr = fr + 1, ee = fe + 1, nn = fn + 1, f_cnt = ff + 1;
    int step = 0;
    int total = mm * cc * rr * ee * nn * f_cnt;
    @(negedge clk_i);
    set_sizes(fm, fc, fr, fe, fn, ff);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    set_sizes(15 - fm, 15 - fc, 15 - fr, 15 - fe, 15 - fn, 15 - ff); // R2: must be ignored
    for (int f = 0; f < f_cnt; f++)
      for (int n = 0; n < nn; n++)
        for (int e = 0; e < ee; e++)
          for (int r = 0; r < rr; r++)
            for (int c = 0; c < cc; c++)
              for (int m = 0; m < mm; m++) begin
                int ep, ew, ei;
                ep = (m + e*mm + n*ee*mm + f*nn*ee*mm) & AMASK;
                ew = (m + c*mm + r*cc*mm) & AMASK;
                ei = (c + r*cc + e*rr*cc + n*ee*rr*cc + f*nn*ee*rr*cc) & AMASK;
                chk({tag, " R3 valid"}, int'(valid_o), 1);
                chk({tag, " R4 psum"}, int'(psum_addr_o), ep);
                chk({tag, " R5 wgt"}, int'(wgt_addr_o), ew);
                chk({tag, " R6 ifm"}, int'(ifm_addr_o), ei);
                chk({tag, " R7 last"}, int'(last_o), (step == total - 1) ? 1 : 0);
                chk({tag, " R8 done low in walk"}, int'(done_o), 0);
                start_i = (step == poke);  // R9 start while running
                step++;
                @(negedge clk_i);
              end
    start_i = 1'b0;
    chk({tag, " R8 done"}, int'(done_o), 1);
    chk({tag, " R8 valid low"}, int'(valid_o), 0);
    chk({tag, " R7 last low"}, int'(last_o), 0);
    @(negedge clk_i);
    chk({tag, " R8 done width"}, int'(done_o), 0);
    chk({tag, " R9 stays idle"}, int'(valid_o), 0);
  endtask

  task automatic t_reset;
    chk("R1 valid in reset", int'(valid_o), 0);
    chk("R1 done in reset", int'(done_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 last", int'(last_o), 0);
    chk("R1 done", int'(done_o), 0);
  endtask

  task automatic t_basic;
    run_case(2, 1, 2, 1, 0, 1, -1, "basic");
  endtask

  task automatic t_single;  // R11
    run_case(0, 0, 0, 0, 0, 0, -1, "R11 single");
  endtask

  task automatic t_start_ignored;  // R9
    run_case(1, 2, 0, 2, 1, 0, 5, "R9 poke");
  endtask

  task automatic t_deep_input;
    run_case(0, 15, 3, 1, 0, 0, -1, "cdeep");
  endtask

  task automatic t_wrap;  // R10
    run_case(15, 0, 0, 15, 15, 3, -1, "R10 wrap");
  endtask

  initial begin
    bit hung;
    hung = 1'b0;
    fork
      begin
        t_reset();
        t_basic();
        t_single();
        t_start_ignored();
        t_deep_input();
        t_wrap();
      end
      begin
        while (cyc < 150000) @(posedge clk_i) cyc++;
        hung = 1'b1;
      end
    join_any
    if (hung) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule